// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block computes how a 32-bit processor core takes an exception. Three request inputs arrive at once: a general exception with a five-bit cause code and a TLB-refill qualifier, an error-level request (non-maskable interrupt or soft reset) and a debug request. The block also receives the architectural state that an exception touches: the current PC, the branch-delay-slot flag, the user and debug mode flags, and the Status, Cause, exception return, error return, debug return and watch registers.

One request is accepted per cycle. The block produces the next value of every one of those registers and the new fetch PC. All results are registered and appear one cycle after the request. A single-cycle `redirect_o` pulse tells the fetch stage to restart at `pc_o`. When no request is present, the outputs repeat the inputs one cycle later unchanged, so the unit can sit in line with the state registers of a pipeline.

Top module: `exc_entry_unit`

## Requirements
- R1: A general exception sets `pc_o` to a base plus an offset. The base is 0xBFC00200 when Status bit 22 (BEV) is 1 and 0x80000000 when it is 0. The offset is 0x180 unless R2 applies.
- R2: When `tlb_refill_i` is 1, the cause code is 2 (load) or 3 (store) and Status bit 1 (EXL) is 0, a general exception uses offset 0x000.
- R3: A general exception writes its cause code into Cause bits 6:2. Cause bits 30:7 and 1:0 keep their input values.
- R4: A general exception with EXL clear saves a return address in `epc_o` and sets Cause bit 31 (BD). If `delay_slot_i` is 1, the return address is PC-4 and BD is 1. Otherwise the return address is PC and BD is 0.
- R5: A general exception with EXL already set leaves `epc_o` and Cause bit 31 at their input values. The cause code is still written.
- R6: A general exception sets Status bit 1, clears user mode and clears the delay-slot flag. All other Status bits are kept.
- R7: An error request ORs into Status the following bits: ERL (bit 2), BEV (bit 22), and either NMI (bit 19, when `err_soft_i`=0) or SR (bit 20, when `err_soft_i`=1). It saves `errorepc_o` with the delay-slot rule of R4, clears user mode and the delay-slot flag, and sets `pc_o` to 0xBFC00000. Cause and the other Status bits are unchanged.
- R8: A soft reset clears `watchlo_o`. Every other accepted or absent request leaves it at its input value.
- R9: A debug request saves `depc_o` with the delay-slot rule of R4, sets debug mode, clears user mode and the delay-slot flag, and sets `pc_o` to 0xBFC00480. Status and Cause are unchanged.
- R10: The priority order is debug, then error, then general. A request that loses arbitration has no effect on any output in that cycle.
- R11: All outputs update on the clock edge after the request. `redirect_o` is 1 for exactly the cycle following an accepted request. With no request, every output repeats its input (and `pc_o` repeats `pc_i`) one cycle later, and `redirect_o` is 0.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_req_i | input | 1 | General exception request |
| gen_code_i | input | 5 | Cause code of the general exception |
| tlb_refill_i | input | 1 | The TLB miss is a refill miss |
| err_req_i | input | 1 | Error-level request |
| err_soft_i | input | 1 | 1: soft reset, 0: non-maskable interrupt |
| dbg_req_i | input | 1 | Debug exception request |
| pc_i | input | 32 | PC of the faulting instruction |
| delay_slot_i | input | 1 | The instruction is in a branch delay slot |
| user_mode_i | input | 1 | Current user mode flag |
| debug_mode_i | input | 1 | Current debug mode flag |
| status_i | input | 32 | Current Status |
| cause_i | input | 32 | Current Cause |
| epc_i | input | 32 | Current exception return address |
| errorepc_i | input | 32 | Current error return address |
| depc_i | input | 32 | Current debug return address |
| watchlo_i | input | 32 | Current watch register |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| pc_o | output | 32 | New PC |
| status_o | output | 32 | Next Status |
| cause_o | output | 32 | Next Cause |
| epc_o | output | 32 | Next exception return address |
| errorepc_o | output | 32 | Next error return address |
| depc_o | output | 32 | Next debug return address |
| watchlo_o | output | 32 | Next watch register |
| user_mode_o | output | 1 | Next user mode flag |
| debug_mode_o | output | 1 | Next debug mode flag |
| delay_slot_o | output | 1 | Next delay-slot flag |

## Verification
Every result of this unit, including the redirect strobe, is due exactly one clock edge after the request cycle, because one register rank sits between the inputs and the outputs. The bench changes inputs on the falling edge and samples all outputs on the next falling edge. At that point the single capturing edge has passed and the next stimulus has not yet been applied. The sweep covers every combination of request bits, both error kinds, the delay-slot flag, BEV, EXL, the refill qualifier and the four cause codes. Vectors without a request confirm that the outputs pass the inputs through on the same one-cycle schedule.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 5;

  // Status / Cause bit positions decoded by neighbouring logic
  localparam int unsigned ST_EXL   = 1;
  localparam int unsigned ST_ERL   = 2;
  localparam int unsigned ST_NMI   = 19;
  localparam int unsigned ST_SR    = 20;
  localparam int unsigned ST_BEV   = 22;
  localparam int unsigned CA_BD    = 31;
  localparam int unsigned CA_CODE  = 2;

  localparam logic [CODE_W-1:0] CODE_REFILL_LD = 5'd2;
  localparam logic [CODE_W-1:0] CODE_REFILL_ST = 5'd3;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_GEN  = 3'd1,
    EXC_NMI  = 3'd2,
    EXC_SRST = 3'd3,
    EXC_DBG  = 3'd4
  } exc_cls_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     gen_req_i,
  input  logic     err_req_i,
  input  logic     err_soft_i,
  input  logic     dbg_req_i,
  output exc_cls_e cls_o
);
  always_comb begin
    if (dbg_req_i)      cls_o = EXC_DBG;
    else if (err_req_i) cls_o = err_soft_i ? EXC_SRST : EXC_NMI;
    else if (gen_req_i) cls_o = EXC_GEN;
    else                cls_o = EXC_NONE;
  end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            delay_slot_i,
  output logic [XLEN-1:0] ret_o,
  output logic            bd_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // restart at the branch when the fault sits in its delay slot
  assign ret_o = delay_slot_i ? (pc_i - STEP) : pc_i;
  assign bd_o  = delay_slot_i;
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int unsigned   XLEN      = 32,
  parameter logic [31:0]   BOOT_BASE = 32'hBFC0_0000,
  parameter logic [31:0]   RUN_BASE  = 32'h8000_0000,
  parameter logic [31:0]   GEN_BOOT  = 32'h0000_0200,
  parameter logic [31:0]   DBG_OFF   = 32'h0000_0480,
  parameter logic [31:0]   GEN_OFF   = 32'h0000_0180,
  parameter logic [31:0]   REFILL_OFF = 32'h0000_0000
) (
  input  exc_cls_e          cls_i,
  input  logic              bev_i,
  input  logic              exl_i,
  input  logic              refill_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [XLEN-1:0]   vec_o
);
  logic            refill_hit;
  logic [XLEN-1:0] gen_base;
  logic [XLEN-1:0] gen_off;

  assign refill_hit = refill_i && !exl_i &&
                      (code_i == CODE_REFILL_LD || code_i == CODE_REFILL_ST);
  assign gen_base   = bev_i ? XLEN'(BOOT_BASE + GEN_BOOT) : XLEN'(RUN_BASE);
  assign gen_off    = refill_hit ? XLEN'(REFILL_OFF) : XLEN'(GEN_OFF);

  always_comb begin
    unique case (cls_i)
      EXC_GEN:           vec_o = gen_base + gen_off;
      EXC_NMI, EXC_SRST: vec_o = XLEN'(BOOT_BASE);
      EXC_DBG:           vec_o = XLEN'(BOOT_BASE + DBG_OFF);
      default:           vec_o = pc_i;
    endcase
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_req_i,
  input  logic [CODE_W-1:0] gen_code_i,
  input  logic              tlb_refill_i,
  input  logic              err_req_i,
  input  logic              err_soft_i,
  input  logic              dbg_req_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              delay_slot_i,
  input  logic              user_mode_i,
  input  logic              debug_mode_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic [XLEN-1:0]   errorepc_i,
  input  logic [XLEN-1:0]   depc_i,
  input  logic [XLEN-1:0]   watchlo_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   errorepc_o,
  output logic [XLEN-1:0]   depc_o,
  output logic [XLEN-1:0]   watchlo_o,
  output logic              user_mode_o,
  output logic              debug_mode_o,
  output logic              delay_slot_o
);
  exc_cls_e        cls;
  logic [XLEN-1:0] ret_addr;
  logic            ret_bd;
  logic [XLEN-1:0] vec_pc;

  logic [XLEN-1:0] status_n, cause_n, epc_n, errorepc_n, depc_n, watchlo_n, pc_n;
  logic            user_n, debug_n, delay_n, redirect_n;

  exc_arbiter u_arb (
    .gen_req_i  (gen_req_i),
    .err_req_i  (err_req_i),
    .err_soft_i (err_soft_i),
    .dbg_req_i  (dbg_req_i),
    .cls_o      (cls)
  );

  // one return-address path shared: only one class wins per cycle
  exc_ret_addr #(.XLEN(XLEN)) u_ret (
    .pc_i         (pc_i),
    .delay_slot_i (delay_slot_i),
    .ret_o        (ret_addr),
    .bd_o         (ret_bd)
  );

  exc_vector #(.XLEN(XLEN)) u_vec (
    .cls_i    (cls),
    .bev_i    (status_i[ST_BEV]),
    .exl_i    (status_i[ST_EXL]),
    .refill_i (tlb_refill_i),
    .code_i   (gen_code_i),
    .pc_i     (pc_i),
    .vec_o    (vec_pc)
  );

  always_comb begin
    status_n   = status_i;
    cause_n    = cause_i;
    epc_n      = epc_i;
    errorepc_n = errorepc_i;
    depc_n     = depc_i;
    watchlo_n  = watchlo_i;
    user_n     = user_mode_i;
    debug_n    = debug_mode_i;
    delay_n    = delay_slot_i;
    pc_n       = vec_pc;
    redirect_n = (cls != EXC_NONE);
    unique case (cls)
      EXC_GEN: begin
        if (!status_i[ST_EXL]) begin
          epc_n          = ret_addr;
          cause_n[CA_BD] = ret_bd;
        end
        cause_n[CA_CODE +: CODE_W] = gen_code_i;
        status_n[ST_EXL]           = 1'b1;
        user_n                     = 1'b0;
        delay_n                    = 1'b0;
      end
      EXC_NMI, EXC_SRST: begin
        status_n[ST_ERL] = 1'b1;
        status_n[ST_BEV] = 1'b1;
        if (cls == EXC_SRST) begin
          status_n[ST_SR] = 1'b1;
          watchlo_n       = '0;
        end else begin
          status_n[ST_NMI] = 1'b1;
        end
        errorepc_n = ret_addr;
        user_n     = 1'b0;
        delay_n    = 1'b0;
      end
      EXC_DBG: begin
        depc_n  = ret_addr;
        debug_n = 1'b1;
        user_n  = 1'b0;
        delay_n = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o   <= 1'b0;
      pc_o         <= '0;
      status_o     <= '0;
      cause_o      <= '0;
      epc_o        <= '0;
      errorepc_o   <= '0;
      depc_o       <= '0;
      watchlo_o    <= '0;
      user_mode_o  <= 1'b0;
      debug_mode_o <= 1'b0;
      delay_slot_o <= 1'b0;
    end else begin
      redirect_o   <= redirect_n;
      pc_o         <= pc_n;
      status_o     <= status_n;
      cause_o      <= cause_n;
      epc_o        <= epc_n;
      errorepc_o   <= errorepc_n;
      depc_o       <= depc_n;
      watchlo_o    <= watchlo_n;
      user_mode_o  <= user_n;
      debug_mode_o <= debug_n;
      delay_slot_o <= delay_n;
    end
  end
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
  import exc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gen_req_i,
  input logic [CODE_W-1:0] gen_code_i,
  input logic              err_req_i,
  input logic              err_soft_i,
  input logic              dbg_req_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              delay_slot_i,
  input logic [XLEN-1:0]   status_i,
  input logic [XLEN-1:0]   cause_i,
  input logic [XLEN-1:0]   epc_i,
  input logic [XLEN-1:0]   watchlo_i,
  input logic              redirect_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [XLEN-1:0]   epc_o,
  input logic [XLEN-1:0]   watchlo_o,
  input logic              user_mode_o,
  input logic              debug_mode_o,
  input logic              delay_slot_o
);
  logic any_req, gen_only, err_only;
  assign any_req  = gen_req_i || err_req_i || dbg_req_i;
  assign gen_only = gen_req_i && !err_req_i && !dbg_req_i;
  assign err_only = err_req_i && !dbg_req_i;

  a_r11_redirect_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> redirect_o);
  a_r11_no_redirect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> !redirect_o && pc_o == $past(pc_i));
  a_r3_code_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_only |=> cause_o[6:2] == $past(gen_code_i) &&
                 cause_o[30:7] == $past(cause_i[30:7]) &&
                 cause_o[1:0] == $past(cause_i[1:0]));
  a_r4_epc_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_only && !status_i[ST_EXL] && !delay_slot_i |=> epc_o == $past(pc_i) && !cause_o[CA_BD]);
  a_r5_nested_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_only && status_i[ST_EXL] |=> epc_o == $past(epc_i) && cause_o[CA_BD] == $past(cause_i[CA_BD]));
  a_r6_exl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_only |=> status_o[ST_EXL] && !user_mode_o && !delay_slot_o);
  a_r7_error_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_only |=> pc_o == 32'hBFC0_0000 && status_o[ST_ERL] && status_o[ST_BEV] && !user_mode_o);
  a_r8_watch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_only && err_soft_i) |=> watchlo_o == $past(watchlo_i));
  a_r9_debug_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_i |=> pc_o == 32'hBFC0_0480 && debug_mode_o && !user_mode_o &&
                  status_o == $past(status_i));
endmodule

bind exc_entry_unit exc_entry_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gen_req_i    (gen_req_i),
  .gen_code_i   (gen_code_i),
  .err_req_i    (err_req_i),
  .err_soft_i   (err_soft_i),
  .dbg_req_i    (dbg_req_i),
  .pc_i         (pc_i),
  .delay_slot_i (delay_slot_i),
  .status_i     (status_i),
  .cause_i      (cause_i),
  .epc_i        (epc_i),
  .watchlo_i    (watchlo_i),
  .redirect_o   (redirect_o),
  .pc_o         (pc_o),
  .status_o     (status_o),
  .cause_o      (cause_o),
  .epc_o        (epc_o),
  .watchlo_o    (watchlo_o),
  .user_mode_o  (user_mode_o),
  .debug_mode_o (debug_mode_o),
  .delay_slot_o (delay_slot_o)
);

// File: tb/exc_entry_unit_tb_top.sv
module exc_entry_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gen_req_i = 0, tlb_refill_i = 0, err_req_i = 0, err_soft_i = 0, dbg_req_i = 0;
  logic [4:0]  gen_code_i = '0;
  logic [31:0] pc_i = '0, status_i = '0, cause_i = '0, epc_i = '0;
  logic [31:0] errorepc_i = '0, depc_i = '0, watchlo_i = '0;
  logic        delay_slot_i = 0, user_mode_i = 0, debug_mode_i = 0;
  logic        redirect_o, user_mode_o, debug_mode_o, delay_slot_o;
  logic [31:0] pc_o, status_o, cause_o, epc_o, errorepc_o, depc_o, watchlo_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_unit dut_i (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] codes [4];
    codes[0] = 5'd2; codes[1] = 5'd3; codes[2] = 5'd8; codes[3] = 5'd31;

    #1;
    // R12: outputs held at zero in reset
    chk("R12", "pc", pc_o, 32'h0);
    chk("R12", "status", status_o, 32'h0);
    chk("R12", "redirect", {31'b0, redirect_o}, 32'h0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R12", "epc", epc_o, 32'h0);
    rst_ni = 1'b1;

    for (int m = 0; m < 8; m++)
    for (int sft = 0; sft < 2; sft++)
    for (int ds = 0; ds < 2; ds++)
    for (int bev = 0; bev < 2; bev++)
    for (int exl = 0; exl < 2; exl++)
    for (int rf = 0; rf < 2; rf++)
    for (int ci = 0; ci < 4; ci++) begin
      int          idx;
      logic [31:0] e_pc, e_st, e_ca, e_epc, e_eepc, e_depc, e_wl, ret;
      logic        e_um, e_dm, e_ds, e_rd;
      string       t_pc, t_epc, t_st, t_misc;
      idx = ((((m*2+sft)*2+ds)*2+bev)*2+exl)*8 + rf*4 + ci;

      @(negedge clk_i);
      gen_req_i    = m[0];
      err_req_i    = m[1];
      dbg_req_i    = m[2];
      err_soft_i   = sft[0];
      delay_slot_i = ds[0];
      tlb_refill_i = rf[0];
      gen_code_i   = codes[ci];
      pc_i         = 32'h0040_0000 + idx * 32'h14;
      status_i     = (32'h0000_FF10 ^ (idx * 32'h0001_0101)) & ~32'h0058_0006;
      status_i[22] = bev[0];
      status_i[1]  = exl[0];
      cause_i      = 32'h8000_0000 ^ (idx * 32'h0102_0305);
      epc_i        = 32'h1111_0000 + idx;
      errorepc_i   = 32'h2222_0000 + idx;
      depc_i       = 32'h3333_0000 + idx;
      watchlo_i    = 32'h4444_0000 + idx;
      user_mode_i  = ~idx[0];
      debug_mode_i = idx[1];

      // reference from requirements
      ret    = ds[0] ? pc_i - 32'd4 : pc_i;
      e_pc   = pc_i; e_st = status_i; e_ca = cause_i; e_epc = epc_i;
      e_eepc = errorepc_i; e_depc = depc_i; e_wl = watchlo_i;
      e_um   = user_mode_i; e_dm = debug_mode_i; e_ds = delay_slot_i; e_rd = 1'b0;
      t_pc = "R11"; t_epc = "R11"; t_st = "R11"; t_misc = "R11";
      if (m[2]) begin
        e_depc = ret; e_dm = 1'b1; e_um = 1'b0; e_ds = 1'b0; e_rd = 1'b1;
        e_pc = 32'hBFC0_0480; t_pc = "R9"; t_misc = "R9";
      end else if (m[1]) begin
        e_st = status_i | 32'h0040_0004 | (sft[0] ? 32'h0010_0000 : 32'h0008_0000);
        if (sft[0]) e_wl = 32'h0;
        e_eepc = ret; e_um = 1'b0; e_ds = 1'b0; e_rd = 1'b1;
        e_pc = 32'hBFC0_0000; t_pc = "R7"; t_st = "R7"; t_misc = sft[0] ? "R8" : "R7";
      end else if (m[0]) begin
        e_pc = (bev[0] ? 32'hBFC0_0200 : 32'h8000_0000) +
               ((rf[0] && !exl[0] && (ci < 2)) ? 32'h0 : 32'h180);
        t_pc = (rf[0] && !exl[0] && (ci < 2)) ? "R2" : "R1";
        if (!exl[0]) begin
          e_epc = ret; e_ca[31] = ds[0]; t_epc = "R4";
        end else t_epc = "R5";
        e_ca[6:2] = codes[ci];
        e_st[1] = 1'b1; e_um = 1'b0; e_ds = 1'b0; e_rd = 1'b1;
        t_st = "R6"; t_misc = "R3";
      end
      if (m == 3 || m > 4) begin
        t_pc = "R10"; t_epc = "R10"; t_st = "R10"; t_misc = "R10";
      end

      @(negedge clk_i);
      chk(t_pc,   "pc",       pc_o,       e_pc);
      chk(t_st,   "status",   status_o,   e_st);
      chk(t_misc, "cause",    cause_o,    e_ca);
      chk(t_epc,  "epc",      epc_o,      e_epc);
      chk(t_misc, "errorepc", errorepc_o, e_eepc);
      chk(t_misc, "depc",     depc_o,     e_depc);
      chk(t_misc, "watchlo",  watchlo_o,  e_wl);
      chk(t_st,   "user",     {31'b0, user_mode_o},  {31'b0, e_um});
      chk(t_misc, "debug",    {31'b0, debug_mode_o}, {31'b0, e_dm});
      chk(t_st,   "delay",    {31'b0, delay_slot_o}, {31'b0, e_ds});
      chk("R11",  "redirect", {31'b0, redirect_o},   {31'b0, e_rd});
    end

    // R11: strobe drops once requests stop
    gen_req_i = 0; err_req_i = 0; dbg_req_i = 0;
    @(negedge clk_i);
    chk("R11", "redirect_idle", {31'b0, redirect_o}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule